// File: doc/BRIEF.md
# ADC Result Queue with Fill-Level Interrupt

This block buffers analog conversion results produced by a scan sequencer until software collects them. Each time the sequencer raises its result-valid strobe, the 10-bit result and the 5-bit number of the channel it came from are packed into one 16-bit word. That word is appended to a 16-deep first-in first-out queue. Software pulls entries out one at a time by strobing a read of a single data word. Each read pops the oldest entry into a registered output.

Empty and full flags report the queue state. A sticky overrun flag records that a result was lost. A clear strobe discards all stored entries in one cycle. A programmable threshold sets a sticky interrupt flag once enough entries are waiting. The interrupt line to the processor is that flag gated by an enable bit.

Top module: `adc_result_queue`

## Requirements
- R1: Entries are returned in the order they were written. Up to 16 entries are held.
- R2: A read of a non-empty queue loads `rdData` at the clock edge where `rdStrobe` is sampled. The word carries the result in bits 15:6, a 0 in bit 5 and the channel in bits 4:0. `rdData` is 0 after reset.
- R3: `isEmpty` is 1 after reset and whenever no entry is stored. It drops at the edge where a write is accepted into an empty queue.
- R4: `isFull` is 1 exactly when 16 entries are stored.
- R5: A write sampled while the queue is full is discarded and sets `overrunFlag`. The flag stays at 1 until an `ovrClear` strobe. If a discarded write and `ovrClear` arrive in the same cycle, the flag is set.
- R6: `queueClear` empties the queue at the next edge, so `isEmpty` is 1 and `isFull` is 0 after it. It overrides a write or a read in the same cycle. It leaves `rdData` and `overrunFlag` unchanged.
- R7: `irqFlag` is set at the edge where the stored count becomes at least `thrCfg`+1. It then stays at 1 even after the count falls.
- R8: `flagClear` forces `irqFlag` to 0 at the next edge. If the count still meets the threshold, the flag sets again at the edge after that.
- R9: `irqOut` is 1 only when both `irqFlag` and `irqEnable` are 1.
- R10: A read of an empty queue leaves `rdData` and the read position unchanged. A later write is then read back correctly.
- R11: A read and a write in the same cycle are both accepted when the queue is neither empty nor full. When the queue is empty, only the write is accepted. When it is full, only the read is accepted and the write counts as an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Result-valid strobe from the sequencer |
| wrResult | input | 10 | Conversion result |
| wrChannel | input | 5 | Channel number of the result |
| rdStrobe | input | 1 | Data-word read strobe, pops one entry |
| queueClear | input | 1 | Discard all stored entries |
| ovrClear | input | 1 | Clear the overrun flag |
| flagClear | input | 1 | Clear the interrupt flag (software writes 0) |
| thrCfg | input | 4 | Threshold: flag sets at thrCfg+1 entries |
| irqEnable | input | 1 | Interrupt enable |
| rdData | output | 16 | Last popped entry |
| isEmpty | output | 1 | No entries stored |
| isFull | output | 1 | 16 entries stored |
| overrunFlag | output | 1 | Sticky lost-result flag |
| irqFlag | output | 1 | Sticky threshold flag |
| irqOut | output | 1 | Gated interrupt request |

## Verification
The hardest situation to reach is a simultaneous read and write against a full queue. The queue must be filled exactly to 16 without an intervening read, so random traffic seldom lands there. A directed phase fills the queue, overflows it and then issues a combined read and write. A random phase follows with writes weighted above reads, so the queue keeps returning to the full boundary. Clearing the interrupt flag while the count still meets the threshold is also forced directly, to observe the flag dropping and then setting again.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } adcqStrobes_t;
endpackage

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
  import adcq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             rdStrobe,
  input  logic             queueClear,
  input  logic             ovrClear,
  output adcqStrobes_t     strobes,
  output logic [CNT_W-1:0] nextCount,
  output logic             isEmpty,
  output logic             isFull,
  output logic             overrunFlag
);
  logic [CNT_W-1:0] count;
  logic             lostWrite;

  assign isEmpty   = (count == '0);
  assign isFull    = (count == CNT_W'(DEPTH));
  assign lostWrite = wrValid && isFull;

  always_comb begin
    strobes.flush = queueClear;
    strobes.push  = wrValid && !isFull && !queueClear;
    strobes.pop   = rdStrobe && !isEmpty && !queueClear;
    if (queueClear) nextCount = '0;
    else nextCount = count + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count       <= '0;
      overrunFlag <= 1'b0;
    end else begin
      count <= nextCount;
      if (lostWrite) overrunFlag <= 1'b1;
      else if (ovrClear) overrunFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/adcq_datapath.sv
module adcq_datapath
  import adcq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int RES_W  = 10,
  parameter int CH_W   = 5,
  parameter int DATA_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int GAP_W = DATA_W - RES_W - CH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  adcqStrobes_t      strobes,
  input  logic [RES_W-1:0]  wrResult,
  input  logic [CH_W-1:0]   wrChannel,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] packedWord;

  assign packedWord = {wrResult, {GAP_W{1'b0}}, wrChannel};

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobes.push && (wrPtr == PTR_W'(i))) mem[i] <= packedWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else if (strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= bump(wrPtr);
      if (strobes.pop) begin
        rdData <= mem[rdPtr];
        rdPtr  <= bump(rdPtr);
      end
    end
  end
endmodule

// File: rtl/adcq_irq.sv
module adcq_irq #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] nextCount,
  input  logic [THR_W-1:0] thrCfg,
  input  logic             flagClear,
  input  logic             irqEnable,
  output logic             irqFlag,
  output logic             irqOut
);
  logic [CNT_W:0] trigLevel;
  logic           reached;

  assign trigLevel = (CNT_W + 1)'(thrCfg) + 1'b1;
  assign reached   = ({1'b0, nextCount} >= trigLevel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqFlag <= 1'b0;
    else if (flagClear) irqFlag <= 1'b0;
    else if (reached) irqFlag <= 1'b1;
  end

  assign irqOut = irqFlag & irqEnable;
endmodule

// File: rtl/adc_result_queue.sv
module adc_result_queue
  import adcq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int RES_W  = 10,
  parameter int CH_W   = 5,
  parameter int DATA_W = 16,
  parameter int THR_W  = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [RES_W-1:0]  wrResult,
  input  logic [CH_W-1:0]   wrChannel,
  input  logic              rdStrobe,
  input  logic              queueClear,
  input  logic              ovrClear,
  input  logic              flagClear,
  input  logic [THR_W-1:0]  thrCfg,
  input  logic              irqEnable,
  output logic [DATA_W-1:0] rdData,
  output logic              isEmpty,
  output logic              isFull,
  output logic              overrunFlag,
  output logic              irqFlag,
  output logic              irqOut
);
  adcqStrobes_t     strobes;
  logic [CNT_W-1:0] nextCount;

  adcq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk, .rstN, .wrValid, .rdStrobe, .queueClear, .ovrClear,
    .strobes, .nextCount, .isEmpty, .isFull, .overrunFlag
  );

  adcq_datapath #(.DEPTH(DEPTH), .RES_W(RES_W), .CH_W(CH_W), .DATA_W(DATA_W)) dp_i (
    .clk, .rstN, .strobes, .wrResult, .wrChannel, .rdData
  );

  adcq_irq #(.DEPTH(DEPTH), .THR_W(THR_W)) irq_i (
    .clk, .rstN, .nextCount, .thrCfg, .flagClear, .irqEnable, .irqFlag, .irqOut
  );
endmodule

// File: rtl/adcq_checker.sv
module adcq_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              rdStrobe,
  input logic              queueClear,
  input logic              ovrClear,
  input logic              flagClear,
  input logic [DATA_W-1:0] rdData,
  input logic              isEmpty,
  input logic              isFull,
  input logic              overrunFlag,
  input logic              irqFlag,
  input logic              irqOut
);
  AST_NOT_EMPTY_AND_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !(isEmpty && isFull)); // R4
  AST_WRITE_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !queueClear |=> !isEmpty); // R3
  AST_LOST_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && isFull |=> overrunFlag); // R5
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overrunFlag && !ovrClear |=> overrunFlag); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    queueClear |=> isEmpty && !isFull); // R6
  AST_CLEAR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    queueClear |=> $stable(rdData)); // R6
  AST_IRQ_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !flagClear |=> irqFlag); // R7
  AST_IRQ_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flagClear |=> !irqFlag); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqFlag); // R9
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && isEmpty |=> $stable(rdData)); // R10
endmodule

bind adc_result_queue adcq_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
  .queueClear(queueClear), .ovrClear(ovrClear), .flagClear(flagClear),
  .rdData(rdData), .isEmpty(isEmpty), .isFull(isFull),
  .overrunFlag(overrunFlag), .irqFlag(irqFlag), .irqOut(irqOut)
);

// File: tb/adc_result_queue_tb.sv
module adc_result_queue_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [9:0]  wrResult = '0;
  logic [4:0]  wrChannel = '0;
  logic        rdStrobe = 1'b0;
  logic        queueClear = 1'b0;
  logic        ovrClear = 1'b0;
  logic        flagClear = 1'b0;
  logic [3:0]  thrCfg = '0;
  logic        irqEnable = 1'b0;
  logic [15:0] rdData;
  logic        isEmpty, isFull, overrunFlag, irqFlag, irqOut;

  int checks = 0;
  int fails = 0;
  logic [15:0] mq[$];
  logic [15:0] mLast = '0;
  logic        mOvr = 1'b0;
  logic        mFlag = 1'b0;

  always #2 clk = ~clk;

  adc_result_queue dut_i (
    .clk, .rstN, .wrValid, .wrResult, .wrChannel, .rdStrobe, .queueClear,
    .ovrClear, .flagClear, .thrCfg, .irqEnable, .rdData, .isEmpty, .isFull,
    .overrunFlag, .irqFlag, .irqOut
  );

  function automatic logic [15:0] packWord(input logic [9:0] r, input logic [4:0] c);
    return {r, 1'b0, c};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R1/R2/R10", "rdData", rdData, mLast);
    chk("R3", "isEmpty", isEmpty, mq.size() == 0);
    chk("R4", "isFull", isFull, mq.size() == 16);
    chk("R5", "overrunFlag", overrunFlag, mOvr);
    chk("R7/R8", "irqFlag", irqFlag, mFlag);
    chk("R9", "irqOut", irqOut, mFlag && irqEnable);
  endtask

  // Drive one cycle of stimulus, advance the model, check after the edge
  task automatic step(input logic wr, input logic [9:0] r, input logic [4:0] c,
                      input logic rd, input logic clr, input logic oc, input logic fc);
    int n;
    logic full, empty;
    wrValid = wr; wrResult = r; wrChannel = c; rdStrobe = rd;
    queueClear = clr; ovrClear = oc; flagClear = fc;
    n = mq.size();
    full = (n == 16);
    empty = (n == 0);
    if (wr && full) mOvr = 1'b1;
    else if (oc) mOvr = 1'b0;
    if (clr) mq.delete();
    else begin
      if (rd && !empty) mLast = mq.pop_front();
      if (wr && !full) mq.push_back(packWord(r, c));
    end
    if (fc) mFlag = 1'b0;
    else if (mq.size() >= int'(thrCfg) + 1) mFlag = 1'b1;
    @(posedge clk);
    #1;
    checkAll();
    wrValid = 0; rdStrobe = 0; queueClear = 0; ovrClear = 0; flagClear = 0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    checkAll(); // R3 reset state, R2 rdData is 0
    rstN = 1'b1;

    // R7 R9: threshold 3 sets the flag at the fourth entry
    thrCfg = 4'd3; irqEnable = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1, 10'(i + 1), 5'(i), 0, 0, 0, 0);
      chk("R7", "flag at count", irqFlag, i == 3);
    end
    // R8: clearing while the count still meets the threshold
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R8", "flag cleared", irqFlag, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R8", "flag re-set", irqFlag, 1);
    irqEnable = 1'b0;
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R9", "irq gated off", irqOut, 0);

    // R6: clear together with a read and a write
    step(1, 10'h155, 5'h3, 1, 1, 0, 0);
    chk("R6", "empty after clear", isEmpty, 1);
    step(0, 0, 0, 0, 0, 0, 1);

    // R2: field layout
    thrCfg = 4'd15;
    step(1, 10'h2AA, 5'h15, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R2", "packed word", rdData, 16'hAA95);

    // R1 R4 R5: fill, overflow, then read and write together when full
    for (int i = 0; i < 16; i++) step(1, 10'(100 + i), 5'(i), 0, 0, 0, 0);
    chk("R4", "full at 16", isFull, 1);
    step(1, 10'h3FF, 5'h1F, 0, 0, 0, 0);
    chk("R5", "overrun set", overrunFlag, 1);
    step(1, 10'h3FE, 5'h1E, 1, 0, 1, 0);
    chk("R11", "full read+write", rdData, packWord(10'd100, 5'd0));
    chk("R5", "overrun set wins over clear", overrunFlag, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R5", "overrun cleared", overrunFlag, 0);

    // R1 R10: drain, then read empty
    for (int i = 0; i < 15; i++) step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R10", "empty read holds", rdData, packWord(10'd115, 5'd15));
    // R11: read and write on an empty queue
    step(1, 10'h0F0, 5'h07, 1, 0, 0, 0);
    chk("R11", "empty read+write keeps one", isEmpty, 0);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R10", "write after empty read", rdData, packWord(10'h0F0, 5'h07));

    // Random phase, writes weighted above reads
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        thrCfg = 4'($urandom_range(0, 15));
        irqEnable = 1'($urandom_range(0, 1));
      end
      step($urandom_range(0, 99) < 60, 10'($urandom), 5'($urandom),
           $urandom_range(0, 99) < 45, $urandom_range(0, 199) == 0,
           $urandom_range(0, 49) == 0, $urandom_range(0, 29) == 0);
    end
    finishRun();
  end
endmodule